// File: doc/BRIEF.md
# Adaptive low-weight transition encoder

This block drives the sending end of a 32-bit on-chip bus. Its output is a 34-line bundle: 32 data lines, a flag that marks a table code and a flag that marks an inverted word. On each strobed transfer the new word first passes through a filter against the previous input word. The filter either passes the word unchanged, XORs it with the previous word or subtracts the previous word from it. The filtered value is then searched in a small learned table of frequent values.

On a hit, the encoder looks up the frequency rank of the matching entry and turns it into a code of Hamming weight zero or one. It XORs that code onto the data lines it already holds, so the most frequent value causes no wire toggles at all. On a miss, it sends the filtered word as it is, or its complement when the complement toggles fewer lines. It then loads the word into the least-used table slot.

The receiver can run the same table algorithm from what it sees on the wires, so no extra channel is needed to keep the two ends in step. Hit counters are halved as a group when one of them nears its ceiling, which lets the ranking follow the current phase of the traffic.

Top module: `lowweight_bus_encoder`

## Requirements
- R1: A synchronous active-high reset clears the data lines, both flags, the previous-input register, every table value and every hit counter to zero.
- R2: While the strobe is low, the data lines and both flags hold their values, and neither the table nor the previous-input register changes.
- R3: The filter mode input selects the filtered value: 0 passes the raw word, 1 gives the word XOR the previous strobed word, 2 gives the word minus the previous strobed word modulo 2^32, and 3 also passes the raw word.
- R4: A table slot whose counter is zero is empty and never matches. A transfer hits when the filtered value equals the value held in an occupied slot.
- R5: Ranks order the slots by counter, highest first, and a tie goes to the lower slot index. Rank 0 uses the all-zero code, and rank k (1 to 7) uses the code with only data bit k-1 set.
- R6: On a hit, the new data lines equal the old data lines XOR the code of the hit slot's rank, the coded flag is 1 and the invert flag is 0.
- R7: On a miss, the coded flag is 0. If more than 16 data lines would toggle when sending the filtered value, the lines carry its complement and the invert flag is 1. Otherwise they carry the value and the invert flag is 0.
- R8: A hit adds one to the slot's counter. When that sum would reach 255, every counter is shifted right by one bit instead and the hit slot becomes 127, so a slot at count 1 becomes empty.
- R9: On a miss, the filtered value goes into the slot with the lowest counter, with a tie going to the highest index, and that slot's counter becomes 1.
- R10: The outputs change on the clock edge that samples a strobed transfer. Table changes made by that transfer are visible to a strobed transfer on the very next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Transfer strobe |
| in_word | input | 32 | Word to send |
| filt_mode | input | 2 | Filter select (0 raw, 1 XOR, 2 difference, 3 raw) |
| bus_data | output | 32 | Encoded data lines |
| bus_coded | output | 1 | High when the data lines toggled by a table code |
| bus_inv | output | 1 | High when a missed word was sent complemented |

## Verification
A wrong counter, a wrong slot value or a wrong ranking stays hidden until a later transfer hits or misses differently. It then shows as a coded flag that differs from the expected one, or as a toggled data bit in the wrong position. This usually happens within a few strobes in a small value pool. The bench keeps its own model of the table and compares all 34 output lines on every cycle, so any such divergence is reported on the first cycle where it reaches the wires. Directed sequences force the halving and eviction cases, whose effects otherwise appear only when an evicted value comes back.

// File: rtl/lwt_pkg.sv
package lwt_pkg;
  localparam int unsigned BUS_W_DEF = 32;
  localparam int unsigned SLOTS_DEF = 8;
  localparam int unsigned CNT_W_DEF = 8;

  typedef enum logic [1:0] {
    FM_RAW  = 2'd0,
    FM_XOR  = 2'd1,
    FM_SUB  = 2'd2,
    FM_PASS = 2'd3
  } filt_mode_e;
endpackage

// File: rtl/lwt_filter.sv
module lwt_filter #(
  parameter int unsigned DW = 32
) (
  input  logic [1:0]    mode,
  input  logic [DW-1:0] cur,
  input  logic [DW-1:0] prev,
  output logic [DW-1:0] filt
);
  function automatic logic [DW-1:0] apply_filter(lwt_pkg::filt_mode_e m,
                                                 logic [DW-1:0] c,
                                                 logic [DW-1:0] p);
    case (m)
      lwt_pkg::FM_XOR: return c ^ p;
      lwt_pkg::FM_SUB: return c - p;
      default:         return c;
    endcase
  endfunction

  assign filt = apply_filter(lwt_pkg::filt_mode_e'(mode), cur, prev);
endmodule

// File: rtl/lwt_table.sv
module lwt_table #(
  parameter int unsigned DW = 32,
  parameter int unsigned N  = 8,
  parameter int unsigned CW = 8,
  localparam int unsigned IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          upd,
  input  logic [DW-1:0] key,
  output logic          hit,
  output logic [IW-1:0] hit_rank,
  output logic [N-1:0]  match_vec
);
  localparam logic [CW-1:0] CMAX  = '1;
  localparam logic [CW-1:0] CHALF = CMAX >> 1;

  logic [DW-1:0] val_q [N];
  logic [CW-1:0] cnt_q [N];
  logic [IW-1:0] rank_w [N];
  logic [IW-1:0] hit_idx;
  logic [IW-1:0] victim;
  logic [CW-1:0] best_cnt;
  logic [IW:0]   acc;
  logic          wrap_w;

  // slot a ranks ahead of slot b
  function automatic logic ahead(logic [CW-1:0] ca, int ia,
                                 logic [CW-1:0] cb, int ib);
    return (ca > cb) || ((ca == cb) && (ia < ib));
  endfunction

  for (genvar gi = 0; gi < N; gi++) begin : g_cmp
    assign match_vec[gi] = (cnt_q[gi] != '0) && (val_q[gi] == key);
  end

  always_comb begin
    for (int i = 0; i < N; i++) begin
      acc = '0;
      for (int j = 0; j < N; j++) begin
        if (j != i && ahead(cnt_q[j], j, cnt_q[i], i)) acc = acc + 1'b1;
      end
      rank_w[i] = acc[IW-1:0];
    end
  end

  always_comb begin
    hit_idx  = '0;
    hit_rank = '0;
    for (int i = 0; i < N; i++) begin
      if (match_vec[i]) begin
        hit_idx  = hit_idx | IW'(i);
        hit_rank = hit_rank | rank_w[i];
      end
    end
  end

  assign hit = |match_vec;

  always_comb begin
    victim   = '0;
    best_cnt = CMAX;
    for (int i = 0; i < N; i++) begin
      if (cnt_q[i] <= best_cnt) begin
        victim   = IW'(i);
        best_cnt = cnt_q[i];
      end
    end
  end

  assign wrap_w = hit && (cnt_q[hit_idx] == CMAX - 1'b1);

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < N; i++) begin
        val_q[i] <= '0;
        cnt_q[i] <= '0;
      end
    end else if (upd) begin
      if (hit) begin
        if (wrap_w) begin
          for (int i = 0; i < N; i++) cnt_q[i] <= cnt_q[i] >> 1;
          cnt_q[hit_idx] <= CHALF;
        end else begin
          cnt_q[hit_idx] <= cnt_q[hit_idx] + 1'b1;
        end
      end else begin
        val_q[victim] <= key;
        cnt_q[victim] <= CW'(1);
      end
    end
  end
endmodule

// File: rtl/lwt_drive.sv
module lwt_drive #(
  parameter int unsigned DW = 32,
  parameter int unsigned IW = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          fire,
  input  logic          hit,
  input  logic [IW-1:0] hit_rank,
  input  logic [DW-1:0] filt,
  output logic [DW-1:0] bus_data,
  output logic          bus_coded,
  output logic          bus_inv
);
  localparam int unsigned PW = $clog2(DW + 1);
  localparam logic [PW-1:0] HALF = PW'(DW / 2);

  function automatic logic [DW-1:0] rank_code(logic [IW-1:0] r);
    if (r == '0) return '0;
    return DW'(1) << (r - 1'b1);
  endfunction

  function automatic logic [PW-1:0] popcnt(logic [DW-1:0] x);
    logic [PW-1:0] s;
    s = '0;
    for (int i = 0; i < DW; i++) s = s + PW'(x[i]);
    return s;
  endfunction

  logic [PW-1:0] toggles;
  logic          need_inv;

  assign toggles  = popcnt(bus_data ^ filt);
  assign need_inv = toggles > HALF;

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_data  <= '0;
      bus_coded <= 1'b0;
      bus_inv   <= 1'b0;
    end else if (fire) begin
      if (hit) begin
        bus_data  <= bus_data ^ rank_code(hit_rank);
        bus_coded <= 1'b1;
        bus_inv   <= 1'b0;
      end else begin
        bus_data  <= need_inv ? ~filt : filt;
        bus_coded <= 1'b0;
        bus_inv   <= need_inv;
      end
    end
  end
endmodule

// File: rtl/lowweight_bus_encoder.sv
module lowweight_bus_encoder #(
  parameter int unsigned DW = lwt_pkg::BUS_W_DEF,
  parameter int unsigned N  = lwt_pkg::SLOTS_DEF,
  parameter int unsigned CW = lwt_pkg::CNT_W_DEF,
  localparam int unsigned IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          in_valid,
  input  logic [DW-1:0] in_word,
  input  logic [1:0]    filt_mode,
  output logic [DW-1:0] bus_data,
  output logic          bus_coded,
  output logic          bus_inv
);
  logic [DW-1:0] prev_q;
  logic [DW-1:0] filt_w;
  logic          hit_w;
  logic [IW-1:0] hit_rank_w;
  logic [N-1:0]  match_w;

  always_ff @(posedge clk) begin
    if (rst)           prev_q <= '0;
    else if (in_valid) prev_q <= in_word;
  end

  lwt_filter #(.DW(DW)) u_filter (
    .mode(filt_mode), .cur(in_word), .prev(prev_q), .filt(filt_w)
  );

  lwt_table #(.DW(DW), .N(N), .CW(CW)) u_table (
    .clk(clk), .rst(rst), .upd(in_valid), .key(filt_w),
    .hit(hit_w), .hit_rank(hit_rank_w), .match_vec(match_w)
  );

  lwt_drive #(.DW(DW), .IW(IW)) u_drive (
    .clk(clk), .rst(rst), .fire(in_valid), .hit(hit_w),
    .hit_rank(hit_rank_w), .filt(filt_w),
    .bus_data(bus_data), .bus_coded(bus_coded), .bus_inv(bus_inv)
  );
endmodule

module lwt_encoder_chk #(
  parameter int unsigned DW = 32,
  parameter int unsigned N  = 8,
  parameter int unsigned IW = 3
) (
  input logic          clk,
  input logic          rst,
  input logic          in_valid,
  input logic [DW-1:0] bus_data,
  input logic          bus_coded,
  input logic          bus_inv,
  input logic          hit,
  input logic [IW-1:0] hit_rank,
  input logic [N-1:0]  match_vec
);
  p_idle_hold_r2: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> ($stable(bus_data) && $stable(bus_coded) && $stable(bus_inv)));

  p_single_match_r4: assert property (@(posedge clk) disable iff (rst)
    $onehot0(match_vec));

  p_rank_zero_quiet_r5: assert property (@(posedge clk) disable iff (rst)
    (in_valid && hit && hit_rank == '0) |=> $stable(bus_data));

  p_hit_one_toggle_r6: assert property (@(posedge clk) disable iff (rst)
    (in_valid && hit) |=> (bus_coded && !bus_inv &&
                           $countones(bus_data ^ $past(bus_data)) <= 1));

  p_miss_toggle_cap_r7: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !hit) |=> (!bus_coded &&
                            $countones(bus_data ^ $past(bus_data)) <= DW / 2));
endmodule

bind lowweight_bus_encoder lwt_encoder_chk #(.DW(DW), .N(N), .IW(IW)) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .bus_data(bus_data),
  .bus_coded(bus_coded), .bus_inv(bus_inv), .hit(hit_w),
  .hit_rank(hit_rank_w), .match_vec(match_w)
);

// File: tb/tb_lowweight_bus_encoder.sv
module tb_lowweight_bus_encoder;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [31:0] in_word = '0;
  logic [1:0]  filt_mode = '0;
  logic [31:0] bus_data;
  logic        bus_coded;
  logic        bus_inv;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #(CLK_P / 2) clk = ~clk;

  lowweight_bus_encoder dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_word(in_word),
    .filt_mode(filt_mode), .bus_data(bus_data), .bus_coded(bus_coded),
    .bus_inv(bus_inv)
  );

  // behavioural model
  logic [31:0] m_val [8];
  int          m_cnt [8];
  logic [31:0] m_prev, m_bus;
  bit          m_coded, m_inv;
  string       m_tag = "R1";

  function automatic int rank_by_selection(int h);
    bit taken [8];
    int best, rk;
    rk = 0;
    foreach (taken[i]) taken[i] = 0;
    for (int r = 0; r < 8; r++) begin
      best = -1;
      for (int j = 0; j < 8; j++)
        if (!taken[j] && (best < 0 || m_cnt[j] > m_cnt[best])) best = j;
      taken[best] = 1;
      if (best == h) rk = r;
    end
    return rk;
  endfunction

  task automatic model_step();
    logic [31:0] f, code;
    int h, v, rk;
    case (filt_mode)
      2'd1:    f = in_word ^ m_prev;
      2'd2:    f = in_word - m_prev;
      default: f = in_word;
    endcase
    h = -1;
    for (int i = 0; i < 8; i++) if (m_cnt[i] > 0 && m_val[i] == f) h = i;
    if (h >= 0) begin
      rk = rank_by_selection(h);
      code = (rk == 0) ? 32'd0 : (32'd1 << (rk - 1));
      m_bus = m_bus ^ code;
      m_coded = 1; m_inv = 0;
      m_cnt[h] = m_cnt[h] + 1;
      if (m_cnt[h] == 255) for (int i = 0; i < 8; i++) m_cnt[i] = m_cnt[i] / 2;
      m_tag = "R6";
    end else begin
      if ($countones(m_bus ^ f) > 16) begin m_bus = ~f; m_inv = 1; end
      else begin m_bus = f; m_inv = 0; end
      m_coded = 0;
      v = 7;
      for (int i = 6; i >= 0; i--) if (m_cnt[i] < m_cnt[v]) v = i;
      m_val[v] = f; m_cnt[v] = 1;
      m_tag = "R7";
    end
    m_prev = in_word;
  endtask

  always @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < 8; i++) begin m_val[i] = '0; m_cnt[i] = 0; end
      m_prev = '0; m_bus = '0; m_coded = 0; m_inv = 0; m_tag = "R1";
    end else if (in_valid) model_step();
    else m_tag = "R2";
  end

  task automatic chk(bit ok, string tag, logic [33:0] act, logic [33:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (!rst && !finished)
      chk({bus_coded, bus_inv, bus_data} == {m_coded, m_inv, m_bus}, m_tag,
          {bus_coded, bus_inv, bus_data}, {m_coded, m_inv, m_bus});
  end

  function automatic logic [33:0] outs();
    return {bus_coded, bus_inv, bus_data};
  endfunction

  task automatic do_reset();
    rst = 1; in_valid = 0;
    repeat (3) @(negedge clk);
    rst = 0;
  endtask

  task automatic send(logic [31:0] w, logic [1:0] m);
    in_valid = 1; in_word = w; filt_mode = m;
    @(negedge clk);
    in_valid = 0;
  endtask

  initial begin
    #(CLK_P * 200000);
    if (!finished) begin
      bad++; total++;
      $display("FAIL R10 watchdog act=running exp=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    do_reset();
    chk(outs() == 34'd0, "R1", outs(), 34'd0);
    // R4: empty zero slot must not match a zero word
    send(32'd0, 2'd0);
    chk(outs() == 34'd0, "R4", outs(), 34'd0);
    send(32'd5, 2'd0);
    chk(outs() == {2'b00, 32'd5}, "R7", outs(), {2'b00, 32'd5});
    // R10: back-to-back repeat already hits; tie -> lower slot, rank 0
    send(32'd5, 2'd0);
    chk(outs() == {2'b10, 32'd5}, "R10", outs(), {2'b10, 32'd5});
    // R5: zero now rank 1 -> toggles bit 0
    send(32'd0, 2'd0);
    chk(outs() == {2'b10, 32'd4}, "R5", outs(), {2'b10, 32'd4});
    repeat (3) @(negedge clk);
    chk(outs() == {2'b10, 32'd4}, "R2", outs(), {2'b10, 32'd4});
    // R7: inversion chosen
    send(32'hFFFF_FFF0, 2'd0);
    chk(outs() == {2'b01, 32'h0000_000F}, "R7", outs(), {2'b01, 32'h0000_000F});
    // R3: xor, difference and alternate raw
    send(32'hFFFF_FFF5, 2'd1);
    chk(outs() == {2'b10, 32'h0000_000F}, "R3", outs(), {2'b10, 32'h0000_000F});
    send(32'hFFFF_FFFA, 2'd2);
    chk(outs() == {2'b10, 32'h0000_000F}, "R3", outs(), {2'b10, 32'h0000_000F});
    send(32'd0, 2'd3);
    chk(outs() == {2'b10, 32'h0000_000E}, "R3", outs(), {2'b10, 32'h0000_000E});

    // R9: eviction of the single count-1 slot
    do_reset();
    for (int k = 0; k < 8; k++) send(32'd100 + k, 2'd0);
    for (int k = 0; k < 7; k++) send(32'd100 + k, 2'd0);
    send(32'd999, 2'd0);
    send(32'd107, 2'd0);
    chk(bus_coded == 1'b0, "R9", {33'd0, bus_coded}, 34'd0);
    send(32'd100, 2'd0);
    chk(bus_coded == 1'b1, "R9", {33'd0, bus_coded}, 34'd1);

    // R8: halving empties the count-1 slot
    do_reset();
    send(32'd7, 2'd0);
    for (int k = 0; k < 260; k++) send(32'd9, 2'd0);
    send(32'd7, 2'd0);
    chk(bus_coded == 1'b0, "R8", {33'd0, bus_coded}, 34'd0);

    // mixed traffic against the model
    do_reset();
    for (int k = 0; k < 4000; k++) begin
      logic [31:0] w;
      case ($urandom_range(0, 3))
        0: w = 32'h1234_0000 + $urandom_range(0, 5);
        1: w = $urandom();
        default: w = 32'h0000_0040 * $urandom_range(0, 9);
      endcase
      if ($urandom_range(0, 9) < 7) send(w, 2'($urandom_range(0, 3)));
      else @(negedge clk);
    end

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule